// File: doc/BRIEF.md
# 16-Bit Timer-Counter with Sigma-Delta Output

This block is a general-purpose 16-bit timer-counter. The counting clock is picked from the system clock, a set of alternate clock signals or an external input pin. The picked signal may be inverted, passed through a two-flop synchronizer, reduced to rising-edge pulses and divided by a power of two before it steps the counter. Five operating modes are available. Four count in different patterns: free-running up, up to a period value and wrap, down with reload from the period, and up/down between zero and the period. The fifth is a first-order sigma-delta modulator whose one-bit output has a pulse density set by a 16-bit value. An RC low-pass filter turns that output into an analog level.

A sticky overflow flag records every wrap, reload or bottom turn. Software clears it with a one-cycle pulse, and it drives an interrupt when enabled. All configuration is held on plain input ports, so the block can sit behind any register file.

Top module: `tick_timer`

## Requirements
- R1: After reset, `count` is 0 and `ovf_flag`, `irq` and `sd_out` are low.
- R2: In mode 0 the count steps up by one per tick and wraps from 0xFFFF to 0, and that wrap sets the overflow flag. With source 0 and exponent 0, there is one tick per clock cycle.
- R3: In mode 1 the count steps up by one per tick. When it is at or above `period`, the next tick sets it to 0 and sets the flag.
- R4: In mode 2 the count steps down by one per tick. When it is at 0, the next tick reloads `period` and sets the flag.
- R5: In mode 3 the count rises to `period` and then falls to 0. The tick that leaves 0 going up sets the flag; the turn at the top does not.
- R6: With exponent e (0 to 7), a tick occurs on every 2^e-th edge of the selected source.
- R7: When `psc_exp` changes, the prescaler restarts. The edge on which the change is first seen makes no tick, and the next tick comes 2^e clock cycles after that edge.
- R8: Source encoding is 0 for the system clock, 1 to N for `alt_clk[0]` to `alt_clk[N-1]`, and N+1 (3 by default) for `ext_pin`. A non-system source ticks on its rising edge, or on its falling edge when `clk_inv` is set.
- R9: With `sync_en` low, a source edge steps the count on the clock edge where the new level is first sampled. With `sync_en` high, it steps the count two clock edges later.
- R10: Activity on the sources that are not selected never changes the count.
- R11: In mode 4 each tick adds `sd_value` to the 16-bit `count`, and `sd_out` carries the carry of that addition. Over n ticks from reset, `sd_out` is high floor(n*`sd_value`/65536) times. `sd_out` is low in every other mode.
- R12: The flag stays set until an `ovf_clr` pulse, and a new event in the same cycle wins over the clear. `irq` is high exactly when the flag and `irq_en` are both high.
- R13: Mode codes 5 to 7 hold the count unchanged and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Count source select (R8 encoding) |
| alt_clk | input | 2 | Alternate clock signals |
| ext_pin | input | 1 | External count input |
| clk_inv | input | 1 | Count on falling edges of the source |
| sync_en | input | 1 | Route the source through the two-flop synchronizer |
| psc_exp | input | 3 | Prescaler exponent, divide by 2^exp |
| mode | input | 3 | Operating mode (R13 encoding) |
| period | input | 16 | Period or reload value |
| sd_value | input | 16 | Sigma-delta density value |
| irq_en | input | 1 | Interrupt enable |
| ovf_clr | input | 1 | One-cycle clear of the overflow flag |
| count | output | 16 | Counter, or accumulator in mode 4 |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| sd_out | output | 1 | Sigma-delta bit stream |

## Verification
The counting modes are run cycle by cycle from reset against a reference sequence. A short period of 3 or 5 exposes the ordering at the wrap, reload and turn points, and a full 65536-step run shows the natural wrap. Source tests toggle the selected input and the unselected ones in turn, with inversion and with synchronization. These separate edge polarity and the two-cycle retiming delay from plain leakage of other sources. Sigma-delta runs use the values 0, a quarter, a half and the maximum, so the pulse counts over 64 ticks tell an exact carry from an off-by-one accumulator. Prescaler tests measure the spacing between steps, including right after an exponent change.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [2:0] {
        MODE_FREE   = 3'd0,
        MODE_PERIOD = 3'd1,
        MODE_DOWN   = 3'd2,
        MODE_UPDN   = 3'd3,
        MODE_SD     = 3'd4
    } tmr_mode_e;

endpackage

// File: rtl/tmr_clk_path.sv
module tmr_clk_path #(
    parameter int N_ALT = 2,
    parameter int PSC_W = 3,
    parameter int SRC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [N_ALT-1:0] alt_clk,
    input  logic             ext_pin,
    input  logic             clk_inv,
    input  logic             sync_en,
    input  logic [PSC_W-1:0] psc_exp,
    output logic             tick
);
    localparam int PCNT_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [1:0]        sync;
        logic              prev;
        logic [PCNT_W-1:0] pcnt;
        logic [PSC_W-1:0]  psc;
    } path_st_t;

    path_st_t q, d;

    logic [N_ALT:0]    pool;
    logic              sel_lvl;
    logic              lvl;
    logic              samp;
    logic              src_edge;
    logic [PCNT_W-1:0] mask;

    assign pool = {ext_pin, alt_clk};

    always_comb begin
        sel_lvl = ext_pin;
        for (int i = 0; i <= N_ALT; i++) begin
            if (int'(src_sel) == i + 1) sel_lvl = pool[i];
        end
        lvl      = sel_lvl ^ clk_inv;
        samp     = sync_en ? q.sync[1] : lvl;
        src_edge = (src_sel == '0) ? 1'b1 : (samp & ~q.prev);
        mask     = ~({PCNT_W{1'b1}} << psc_exp);

        d      = q;
        tick   = 1'b0;
        d.sync = {q.sync[0], lvl};
        d.prev = samp;
        d.psc  = psc_exp;
        if (psc_exp != q.psc) begin
            d.pcnt = '0;
        end else if (src_edge) begin
            if (q.pcnt == mask) begin
                d.pcnt = '0;
                tick   = 1'b1;
            end else begin
                d.pcnt = q.pcnt + PCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tick_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] period,
    input  logic [W-1:0] sd_value,
    input  logic         ovf_clr,
    output logic [W-1:0] count,
    output logic         ovf_flag,
    output logic         sd_out
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dn;
        logic         ovf;
        logic         sd;
    } core_st_t;

    core_st_t q, d;
    logic     evt;
    logic [W:0] sum;

    always_comb begin
        d   = q;
        evt = 1'b0;
        sum = '0;
        if (mode != MODE_UPDN) d.dn = 1'b0;
        if (mode != MODE_SD)   d.sd = 1'b0;
        if (tick) begin
            case (mode)
                MODE_FREE: begin
                    sum   = {1'b0, q.cnt} + {{W{1'b0}}, 1'b1};
                    d.cnt = sum[W-1:0];
                    evt   = sum[W];
                end
                MODE_PERIOD: begin
                    if (q.cnt >= period) begin
                        d.cnt = '0;
                        evt   = 1'b1;
                    end else begin
                        d.cnt = q.cnt + W'(1);
                    end
                end
                MODE_DOWN: begin
                    if (q.cnt == '0) begin
                        d.cnt = period;
                        evt   = 1'b1;
                    end else begin
                        d.cnt = q.cnt - W'(1);
                    end
                end
                MODE_UPDN: begin
                    if (!q.dn) begin
                        if (q.cnt >= period) begin
                            d.dn  = 1'b1;
                            d.cnt = (q.cnt == '0) ? '0 : q.cnt - W'(1);
                        end else begin
                            d.cnt = q.cnt + W'(1);
                        end
                    end else if (q.cnt == '0) begin
                        d.dn  = 1'b0;
                        d.cnt = (period == '0) ? '0 : W'(1);
                        evt   = 1'b1;
                    end else begin
                        d.cnt = q.cnt - W'(1);
                    end
                end
                MODE_SD: begin
                    sum   = {1'b0, q.cnt} + {1'b0, sd_value};
                    d.cnt = sum[W-1:0];
                    d.sd  = sum[W];
                end
                default: ;
            endcase
        end
        d.ovf = evt | (q.ovf & ~ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count    = q.cnt;
    assign ovf_flag = q.ovf;
    assign sd_out   = q.sd;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int W     = 16,
    parameter int N_ALT = 2,
    parameter int PSC_W = 3,
    localparam int SRC_W = $clog2(N_ALT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [N_ALT-1:0] alt_clk,
    input  logic             ext_pin,
    input  logic             clk_inv,
    input  logic             sync_en,
    input  logic [PSC_W-1:0] psc_exp,
    input  logic [2:0]       mode,
    input  logic [W-1:0]     period,
    input  logic [W-1:0]     sd_value,
    input  logic             irq_en,
    input  logic             ovf_clr,
    output logic [W-1:0]     count,
    output logic             ovf_flag,
    output logic             irq,
    output logic             sd_out
);
    logic tick;

    tmr_clk_path #(
        .N_ALT(N_ALT),
        .PSC_W(PSC_W),
        .SRC_W(SRC_W)
    ) u_path (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .alt_clk (alt_clk),
        .ext_pin (ext_pin),
        .clk_inv (clk_inv),
        .sync_en (sync_en),
        .psc_exp (psc_exp),
        .tick    (tick)
    );

    tmr_core #(
        .W(W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (tmr_mode_e'(mode)),
        .period   (period),
        .sd_value (sd_value),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .ovf_flag (ovf_flag),
        .sd_out   (sd_out)
    );

    assign irq = ovf_flag & irq_en;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int W     = 16,
    parameter int PSC_W = 3,
    parameter int SRC_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_W-1:0] src_sel,
    input logic [PSC_W-1:0] psc_exp,
    input logic [2:0]       mode,
    input logic [W-1:0]     period,
    input logic [W-1:0]     sd_value,
    input logic             irq_en,
    input logic             ovf_clr,
    input logic [W-1:0]     count,
    input logic             ovf_flag,
    input logic             irq,
    input logic             sd_out
);
    a_r2_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREE && src_sel == '0 && psc_exp == '0 && $stable(psc_exp))
        |=> count == W'($past(count) + W'(1)));

    a_r3_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PERIOD && count <= period)
        |=> (!$stable(period) || !$stable(mode) || count <= period));

    a_r4_down_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DOWN && count <= period)
        |=> (!$stable(period) || !$stable(mode) || count <= period));

    a_r11_sd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SD) |=> !sd_out);

    a_r11_sd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SD && sd_value == '0) |=> !sd_out);

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    a_r12_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !ovf_flag) |-> !irq);

    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode > 3'd4) |=> (count == $past(count) && (!ovf_flag || $past(ovf_flag))));

endmodule

bind tick_timer tick_timer_chk #(
    .W(W),
    .PSC_W(PSC_W),
    .SRC_W(SRC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .psc_exp  (psc_exp),
    .mode     (mode),
    .period   (period),
    .sd_value (sd_value),
    .irq_en   (irq_en),
    .ovf_clr  (ovf_clr),
    .count    (count),
    .ovf_flag (ovf_flag),
    .irq      (irq),
    .sd_out   (sd_out)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = '0;
    logic [1:0]  alt_clk = '0;
    logic        ext_pin = 1'b0;
    logic        clk_inv = 1'b0;
    logic        sync_en = 1'b0;
    logic [2:0]  psc_exp = '0;
    logic [2:0]  mode = '0;
    logic [15:0] period = '0;
    logic [15:0] sd_value = '0;
    logic        irq_en = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [15:0] count;
    logic        ovf_flag;
    logic        irq;
    logic        sd_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .alt_clk(alt_clk),
        .ext_pin(ext_pin), .clk_inv(clk_inv), .sync_en(sync_en),
        .psc_exp(psc_exp), .mode(mode), .period(period), .sd_value(sd_value),
        .irq_en(irq_en), .ovf_clr(ovf_clr), .count(count),
        .ovf_flag(ovf_flag), .irq(irq), .sd_out(sd_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic defaults();
        src_sel = '0; alt_clk = '0; ext_pin = 1'b0; clk_inv = 1'b0;
        sync_en = 1'b0; psc_exp = '0; mode = '0; period = '0;
        sd_value = '0; irq_en = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic cycles_to_change(output int n);
        logic [15:0] c0;
        c0 = count;
        n = 0;
        do begin
            step();
            n++;
        end while (count == c0 && n < 1000);
    endtask

    task automatic t_reset();
        defaults();
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 irq", irq, 0);
        chk("R1 sd_out", sd_out, 0);
    endtask

    task automatic t_free();
        defaults();
        do_reset();
        step();
        chk("R2 first step", count, 1);
        repeat (3) step();
        chk("R2 fourth step", count, 4);
        repeat (65531) step();
        chk("R2 top", count, 16'hFFFF);
        chk("R2 no flag before wrap", ovf_flag, 0);
        step();
        chk("R2 wrap to zero", count, 0);
        chk("R2 flag on wrap", ovf_flag, 1);
        chk("R11 sd_out low in mode 0", sd_out, 0);
    endtask

    task automatic t_period();
        int e;
        bit f;
        defaults();
        mode = 3'd1;
        period = 16'd5;
        do_reset();
        e = 0;
        f = 1'b0;
        for (int i = 0; i < 13; i++) begin
            if (e >= 5) begin e = 0; f = 1'b1; end
            else e++;
            step();
            chk("R3 period count", count, e);
            chk("R3 period flag", ovf_flag, f);
        end
    endtask

    task automatic t_down();
        int e;
        bit f;
        defaults();
        mode = 3'd2;
        period = 16'd3;
        do_reset();
        e = 0;
        f = 1'b0;
        for (int i = 0; i < 9; i++) begin
            if (e == 0) begin e = 3; f = 1'b1; end
            else e--;
            step();
            chk("R4 down count", count, e);
            chk("R4 down flag", ovf_flag, f);
        end
    endtask

    task automatic t_updn();
        int e;
        bit dn;
        bit f;
        defaults();
        mode = 3'd3;
        period = 16'd3;
        do_reset();
        e = 0; dn = 1'b0; f = 1'b0;
        for (int i = 0; i < 14; i++) begin
            if (!dn) begin
                if (e >= 3) begin dn = 1'b1; e--; end
                else e++;
            end else if (e == 0) begin
                dn = 1'b0; e = 1; f = 1'b1;
            end else e--;
            step();
            chk("R5 updown count", count, e);
            chk("R5 updown flag", ovf_flag, f);
        end
    endtask

    task automatic t_psc();
        int n;
        defaults();
        psc_exp = 3'd3;
        do_reset();
        cycles_to_change(n);
        cycles_to_change(n);
        chk("R6 spacing at exponent 3", n, 8);
        psc_exp = 3'd7;
        do_reset();
        cycles_to_change(n);
        cycles_to_change(n);
        chk("R6 spacing at exponent 7", n, 128);
        chk("R6 one step per 128", count, 2);
    endtask

    task automatic t_psc_change();
        int n;
        defaults();
        psc_exp = 3'd3;
        do_reset();
        cycles_to_change(n);
        repeat (3) step();
        psc_exp = 3'd1;
        cycles_to_change(n);
        chk("R7 restart after exponent change", n, 3);
        cycles_to_change(n);
        chk("R7 new spacing", n, 2);
    endtask

    task automatic t_ext();
        defaults();
        src_sel = 2'd3;
        do_reset();
        ext_pin = 1'b1;
        step();
        chk("R9 unsynced step on first sample", count, 1);
        repeat (3) step();
        chk("R8 level high no more steps", count, 1);
        ext_pin = 1'b0;
        repeat (2) step();
        chk("R8 falling edge ignored", count, 1);
        clk_inv = 1'b1;
        ext_pin = 1'b1;
        do_reset();
        ext_pin = 1'b0;
        step();
        chk("R8 inverted counts falling edge", count, 1);
        ext_pin = 1'b1;
        repeat (2) step();
        chk("R8 inverted ignores rising edge", count, 1);
        ext_pin = 1'b0;
        step();
        chk("R8 inverted second falling edge", count, 2);
    endtask

    task automatic t_sync();
        defaults();
        src_sel = 2'd3;
        sync_en = 1'b1;
        do_reset();
        ext_pin = 1'b1;
        step();
        chk("R9 sync edge 1", count, 0);
        step();
        chk("R9 sync edge 2", count, 0);
        step();
        chk("R9 sync edge 3", count, 1);
    endtask

    task automatic t_alt();
        defaults();
        src_sel = 2'd2;
        do_reset();
        for (int i = 0; i < 4; i++) begin
            alt_clk[0] = ~alt_clk[0];
            ext_pin = ~ext_pin;
            step();
        end
        chk("R10 unselected sources ignored", count, 0);
        for (int i = 0; i < 6; i++) begin
            alt_clk[1] = ~alt_clk[1];
            step();
        end
        chk("R8 alt_clk[1] rising edges counted", count, 3);
    endtask

    task automatic t_sd(input logic [15:0] v, input int exp_ones);
        int ones;
        defaults();
        mode = 3'd4;
        sd_value = v;
        do_reset();
        ones = 0;
        for (int i = 0; i < 64; i++) begin
            step();
            if (sd_out) ones++;
        end
        chk("R11 sigma-delta ones in 64 ticks", ones, exp_ones);
        chk("R11 accumulator value", count, (64 * int'(v)) % 65536);
    endtask

    task automatic t_irq();
        defaults();
        mode = 3'd1;
        period = 16'd1;
        do_reset();
        repeat (2) step();
        chk("R12 flag set", ovf_flag, 1);
        chk("R12 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        chk("R12 irq follows enable", irq, 1);
        repeat (3) step();
        chk("R12 flag sticky", ovf_flag, 1);
        mode = 3'd5;
        ovf_clr = 1'b1;
        step();
        ovf_clr = 1'b0;
        chk("R12 clear drops flag", ovf_flag, 0);
        chk("R12 irq drops with flag", irq, 0);
        mode = 3'd1;
        period = 16'd0;
        ovf_clr = 1'b1;
        step();
        ovf_clr = 1'b0;
        chk("R12 event wins over clear", ovf_flag, 1);
    endtask

    task automatic t_hold();
        defaults();
        mode = 3'd1;
        period = 16'd9;
        do_reset();
        repeat (4) step();
        chk("R3 before hold", count, 4);
        mode = 3'd6;
        repeat (5) step();
        chk("R13 mode 6 holds count", count, 4);
        mode = 3'd7;
        repeat (5) step();
        chk("R13 mode 7 holds count", count, 4);
        chk("R13 no flag while holding", ovf_flag, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_free();
        t_period();
        t_down();
        t_updn();
        t_psc();
        t_psc_change();
        t_ext();
        t_sync();
        t_alt();
        t_sd(16'h0000, 0);
        t_sd(16'h4000, 16);
        t_sd(16'h8000, 32);
        t_sd(16'hFFFF, 63);
        t_irq();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule